// File: doc/BRIEF.md
# Paged Next Program Counter Unit

This block holds the 15-bit program counter of an 8-bit core and works out the address of the next instruction from the transfer the current instruction asks for. The supported transfers are ordinary sequential advance by the instruction length, one-byte relative jumps whose direction and distance both sit in the opcode byte, two-byte page-local jumps and calls that write a new 12-bit low field under the kept upper PC bits, three-byte absolute jumps, jumps that take their low byte from the accumulator, and table jumps whose low byte comes from a ROM read addressed by the accumulator.

An external decoder presents a coarse transfer kind and the instruction bytes. The unit classifies one-byte and two-byte control opcodes itself, shows the candidate next PC on `nxt_pc_o` in the same cycle, and loads it into the PC register when `step_i` is high at a rising clock edge. For calls it raises `push_o` and shows the return address so that a stack outside the block can store it. For table jumps it shows the ROM address to read, and the fetched byte comes back on `tbyte_i` in the same cycle.

Top module: `pc_nextgen`

## Requirements
- R1: While `rst_ni` is low, and at the first edge after it rises, `pc_o` is 0; reset acts without a clock edge.
- R2: With `kind_i` = 0 (sequential), `nxt_pc_o` = `pc_o` + `len_i` modulo 2^15, and `pc_o` takes `nxt_pc_o` at a rising edge with `step_i` high.
- R3: With `kind_i` = 1 and `opc_i[7:5]` = 3'b000 with a nonzero offset `opc_i[4:0]`, `nxt_pc_o` = `pc_o` + 1 + offset.
- R4: With `kind_i` = 1 and `opc_i` = 8'h00, the instruction is not a jump: `nxt_pc_o` = `pc_o` + `len_i`.
- R5: With `kind_i` = 1 and `opc_i[7:5]` = 3'b111, `nxt_pc_o` = `pc_o` + 1 − 32 + `opc_i[4:0]`, a backward move of 1 to 32 bytes.
- R6: With `kind_i` = 1 and `opc_i[7:4]` = 4'b0010, `nxt_pc_o` = {`pc_o[14:12]`, `opc_i[3:0]`, `op1_i`}.
- R7: With `kind_i` = 1 and `opc_i[7:4]` = 4'b0011, `nxt_pc_o` follows the R6 rule, `push_o` is 1 and `ret_o` = `pc_o` + `len_i` modulo 2^15.
- R8: `push_o` is 0 for every other combination of `kind_i` and `opc_i`.
- R9: With `kind_i` = 2 (absolute), `nxt_pc_o` = {`op1_i[6:0]`, `op2_i`}; `op1_i[7]` is ignored.
- R10: With `kind_i` = 3 (accumulator jump), `nxt_pc_o` = {`pc_o[14:8]`, `acc_i`}.
- R11: `tbl_addr_o` is always {`pc_o[14:8]`, `acc_i`}; with `kind_i` = 4 (table jump), `nxt_pc_o` = {`pc_o[14:8]`, `tbyte_i`}.
- R12: With `step_i` low, `pc_o` keeps its value across clock edges.
- R13: `kind_i` values 5 to 7, and `kind_i` = 1 with an opcode matching none of R3 to R6, give the sequential result of R2.
- R14: Every relative and sequential sum wraps modulo 2^15 across the top and bottom of the address space.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Load the next PC at this edge |
| kind_i | input | 3 | Transfer kind: 0 sequential, 1 opcode-classified, 2 absolute, 3 accumulator jump, 4 table jump |
| opc_i | input | 8 | First instruction byte |
| op1_i | input | 8 | Second instruction byte |
| op2_i | input | 8 | Third instruction byte |
| acc_i | input | 8 | Accumulator value |
| tbyte_i | input | 8 | Byte read from ROM at `tbl_addr_o` |
| len_i | input | 2 | Instruction length in bytes |
| pc_o | output | 15 | Current program counter |
| nxt_pc_o | output | 15 | Next program counter for the presented transfer |
| push_o | output | 1 | Call: return address must be stored |
| ret_o | output | 15 | Return address for a call |
| tbl_addr_o | output | 15 | ROM address for a table read |

## Verification
The hardest situations to reach are the ones that depend on where the PC already sits: a backward relative jump from near address 0, a forward one from near the top, and page transfers from a PC whose upper bits are nonzero. The only way in from the ports is a transfer, so before each table vector the bench issues an absolute jump to the wanted start address and confirms it arrived. After that it applies the vector, compares the same-cycle outputs with its own arithmetic model, and then steps and checks the register.

// File: rtl/npc_pkg.sv
package npc_pkg;

  // coarse transfer kind driven by the external decoder
  typedef enum logic [2:0] {
    XK_SEQ  = 3'd0,
    XK_OPC  = 3'd1,
    XK_LONG = 3'd2,
    XK_IND  = 3'd3,
    XK_TBL  = 3'd4
  } xfer_kind_e;

  // resolved transfer class after opcode inspection
  typedef enum logic [2:0] {
    TC_SEQ,
    TC_FWD,
    TC_BACK,
    TC_PJMP,
    TC_PCALL,
    TC_LONG,
    TC_IND,
    TC_TBL
  } tclass_e;

  localparam int unsigned DEF_PC_W   = 15;
  localparam int unsigned DEF_BYTE_W = 8;
  localparam int unsigned DEF_PAGE_W = 12;
  localparam int unsigned DEF_REL_W  = 5;
  localparam int unsigned DEF_LEN_W  = 2;

endpackage

// File: rtl/npc_opdecode.sv
module npc_opdecode
  import npc_pkg::*;
#(
  parameter int unsigned BYTE_W = DEF_BYTE_W,
  parameter int unsigned REL_W  = DEF_REL_W
) (
  input  logic [2:0]        kind_i,
  input  logic [BYTE_W-1:0] opc_i,
  output tclass_e           cls_o
);
  localparam int unsigned TAG_W = BYTE_W - REL_W;   // direction tag above offset

  logic [TAG_W-1:0] rel_tag;
  logic [REL_W-1:0] rel_off;
  logic [3:0]       page_tag;

  assign rel_tag  = opc_i[BYTE_W-1:REL_W];
  assign rel_off  = opc_i[REL_W-1:0];
  assign page_tag = opc_i[BYTE_W-1:BYTE_W-4];

  always_comb begin
    cls_o = TC_SEQ;
    unique case (kind_i)
      XK_OPC: begin
        if (rel_tag == '0)
          cls_o = (rel_off == '0) ? TC_SEQ : TC_FWD;
        else if (rel_tag == '1)
          cls_o = TC_BACK;
        else if (page_tag == 4'b0010)
          cls_o = TC_PJMP;
        else if (page_tag == 4'b0011)
          cls_o = TC_PCALL;
        else
          cls_o = TC_SEQ;
      end
      XK_LONG: cls_o = TC_LONG;
      XK_IND:  cls_o = TC_IND;
      XK_TBL:  cls_o = TC_TBL;
      default: cls_o = TC_SEQ;
    endcase
  end

endmodule

// File: rtl/npc_target.sv
module npc_target
  import npc_pkg::*;
#(
  parameter int unsigned PC_W   = DEF_PC_W,
  parameter int unsigned BYTE_W = DEF_BYTE_W,
  parameter int unsigned PAGE_W = DEF_PAGE_W,
  parameter int unsigned REL_W  = DEF_REL_W,
  parameter int unsigned LEN_W  = DEF_LEN_W
) (
  input  tclass_e                  cls_i,
  input  logic [PC_W-1:0]          pc_i,
  input  logic [REL_W-1:0]         rel_off_i,
  input  logic [PAGE_W-BYTE_W-1:0] page_hi_i,
  input  logic [BYTE_W-1:0]        op1_i,
  input  logic [BYTE_W-1:0]        op2_i,
  input  logic [BYTE_W-1:0]        acc_i,
  input  logic [BYTE_W-1:0]        tbyte_i,
  input  logic [LEN_W-1:0]         len_i,
  output logic [PC_W-1:0]          nxt_o,
  output logic [PC_W-1:0]          ret_o,
  output logic                     push_o,
  output logic [PC_W-1:0]          tbl_addr_o
);
  localparam int unsigned LONG_W = 2 * BYTE_W;

  // modular add of two PC-wide values
  function automatic logic [PC_W-1:0] f_wrap_add(input logic [PC_W-1:0] a,
                                                 input logic [PC_W-1:0] b);
    return a + b;
  endfunction

  // keep bits above the page field, replace the rest
  function automatic logic [PC_W-1:0] f_splice_page(input logic [PC_W-1:0]   pc,
                                                    input logic [PAGE_W-1:0] fld);
    return {pc[PC_W-1:PAGE_W], fld};
  endfunction

  // keep bits above one byte, replace the low byte
  function automatic logic [PC_W-1:0] f_splice_byte(input logic [PC_W-1:0]   pc,
                                                    input logic [BYTE_W-1:0] lo);
    return {pc[PC_W-1:BYTE_W], lo};
  endfunction

  logic [PC_W-1:0]   seq_pc;
  logic [PC_W-1:0]   rel_base;
  logic [PC_W-1:0]   fwd_pc;
  logic [PC_W-1:0]   back_pc;
  logic [PC_W-1:0]   back_delta;
  logic [PC_W-1:0]   page_pc;
  logic [PC_W-1:0]   long_pc;
  logic [LONG_W-1:0] long_full;
  logic              unused_long_hi;

  assign seq_pc   = f_wrap_add(pc_i, PC_W'(len_i));
  assign rel_base = f_wrap_add(pc_i, PC_W'(1));
  assign fwd_pc   = f_wrap_add(rel_base, PC_W'(rel_off_i));

  // negative step: offset minus 2^REL_W, sign-extended to the PC width
  assign back_delta = {{(PC_W-REL_W){1'b1}}, rel_off_i};
  assign back_pc    = f_wrap_add(rel_base, back_delta);

  assign page_pc   = f_splice_page(pc_i, {page_hi_i, op1_i});
  assign long_full = {op1_i, op2_i};
  assign long_pc   = long_full[PC_W-1:0];
  assign unused_long_hi = ^long_full[LONG_W-1:PC_W];

  assign tbl_addr_o = f_splice_byte(pc_i, acc_i);
  assign ret_o      = seq_pc;
  assign push_o     = (cls_i == TC_PCALL);

  always_comb begin
    unique case (cls_i)
      TC_FWD:   nxt_o = fwd_pc;
      TC_BACK:  nxt_o = back_pc;
      TC_PJMP,
      TC_PCALL: nxt_o = page_pc;
      TC_LONG:  nxt_o = long_pc;
      TC_IND:   nxt_o = f_splice_byte(pc_i, acc_i);
      TC_TBL:   nxt_o = f_splice_byte(pc_i, tbyte_i);
      default:  nxt_o = seq_pc;
    endcase
  end

endmodule

// File: rtl/npc_pcreg.sv
module npc_pcreg #(
  parameter int unsigned PC_W = 15
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            step_i,
  input  logic [PC_W-1:0] nxt_i,
  output logic [PC_W-1:0] pc_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_o <= '0;
    else if (step_i) pc_o <= nxt_i;
  end
endmodule

// File: rtl/pc_nextgen.sv
module pc_nextgen
  import npc_pkg::*;
#(
  parameter int unsigned PC_W   = DEF_PC_W,
  parameter int unsigned BYTE_W = DEF_BYTE_W,
  parameter int unsigned PAGE_W = DEF_PAGE_W,
  parameter int unsigned REL_W  = DEF_REL_W,
  parameter int unsigned LEN_W  = DEF_LEN_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic [2:0]        kind_i,
  input  logic [BYTE_W-1:0] opc_i,
  input  logic [BYTE_W-1:0] op1_i,
  input  logic [BYTE_W-1:0] op2_i,
  input  logic [BYTE_W-1:0] acc_i,
  input  logic [BYTE_W-1:0] tbyte_i,
  input  logic [LEN_W-1:0]  len_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [PC_W-1:0]   nxt_pc_o,
  output logic              push_o,
  output logic [PC_W-1:0]   ret_o,
  output logic [PC_W-1:0]   tbl_addr_o
);
  localparam int unsigned PHI_W = PAGE_W - BYTE_W;   // page bits carried by opcode

  tclass_e   cls;          // decoded class, exposed for assertions
  logic      is_call_opc;  // independent view of the call opcode pattern

  npc_opdecode #(.BYTE_W(BYTE_W), .REL_W(REL_W)) u_dec (
    .kind_i (kind_i),
    .opc_i  (opc_i),
    .cls_o  (cls)
  );

  npc_target #(
    .PC_W(PC_W), .BYTE_W(BYTE_W), .PAGE_W(PAGE_W), .REL_W(REL_W), .LEN_W(LEN_W)
  ) u_tgt (
    .cls_i      (cls),
    .pc_i       (pc_o),
    .rel_off_i  (opc_i[REL_W-1:0]),
    .page_hi_i  (opc_i[PHI_W-1:0]),
    .op1_i      (op1_i),
    .op2_i      (op2_i),
    .acc_i      (acc_i),
    .tbyte_i    (tbyte_i),
    .len_i      (len_i),
    .nxt_o      (nxt_pc_o),
    .ret_o      (ret_o),
    .push_o     (push_o),
    .tbl_addr_o (tbl_addr_o)
  );

  npc_pcreg #(.PC_W(PC_W)) u_pc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step_i),
    .nxt_i  (nxt_pc_o),
    .pc_o   (pc_o)
  );

  assign is_call_opc = (kind_i == 3'd1) && (opc_i[BYTE_W-1:BYTE_W-4] == 4'b0011);

  // R1: register is clear on the edge where reset releases
  a_r1_reset_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (pc_o == '0));

  // R2: a step loads the value shown on the previous cycle
  a_r2_step_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> (pc_o == $past(nxt_pc_o)));

  // R12: no step, no change
  a_r12_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pc_o));

  // R6: page transfers keep the bits above the page field
  a_r6_page_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cls == TC_PJMP) || (cls == TC_PCALL)) |->
      (nxt_pc_o[PC_W-1:PAGE_W] == pc_o[PC_W-1:PAGE_W]));

  // R8: a push request only comes with the call opcode
  a_r8_push_only_call: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_o |-> is_call_opc);

  // R7: the call opcode always requests a push
  a_r7_call_pushes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_call_opc |-> push_o);

  // R10: accumulator jump keeps the upper PC bits and takes the accumulator
  a_r10_ind_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == 3'd3) |->
      ((nxt_pc_o[PC_W-1:BYTE_W] == pc_o[PC_W-1:BYTE_W]) && (nxt_pc_o[BYTE_W-1:0] == acc_i)));

  // R11: table jump stays in the page of the table read
  a_r11_tbl_page: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kind_i == 3'd4) |-> (nxt_pc_o[PC_W-1:BYTE_W] == tbl_addr_o[PC_W-1:BYTE_W]));

endmodule

// File: tb/pc_nextgen_tb.sv
module pc_nextgen_tb_top;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic        step_i;
  logic [2:0]  kind_i;
  logic [7:0]  opc_i, op1_i, op2_i, acc_i, tbyte_i;
  logic [1:0]  len_i;
  logic [14:0] pc_o, nxt_pc_o, ret_o, tbl_addr_o;
  logic        push_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;   // 50 MHz

  pc_nextgen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(step_i), .kind_i(kind_i),
    .opc_i(opc_i), .op1_i(op1_i), .op2_i(op2_i), .acc_i(acc_i),
    .tbyte_i(tbyte_i), .len_i(len_i), .pc_o(pc_o), .nxt_pc_o(nxt_pc_o),
    .push_o(push_o), .ret_o(ret_o), .tbl_addr_o(tbl_addr_o)
  );

  // vector: {start pc 15, kind 3, opc 8, op1 8, op2 8, acc 8, tbyte 8, len 2}
  localparam int NV = 15;
  localparam logic [59:0] VECS [NV] = '{
    {15'h1234, 3'd0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 2'd1},
    {15'h1234, 3'd1, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00, 2'd1},
    {15'h1234, 3'd1, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 2'd1},
    {15'h1234, 3'd1, 8'hE3, 8'h00, 8'h00, 8'h00, 8'h00, 2'd1},
    {15'h0010, 3'd1, 8'hE0, 8'h00, 8'h00, 8'h00, 8'h00, 2'd1},
    {15'h5ABC, 3'd1, 8'h2A, 8'h55, 8'h00, 8'h00, 8'h00, 2'd2},
    {15'h5ABC, 3'd1, 8'h3F, 8'hFF, 8'h00, 8'h00, 8'h00, 2'd2},
    {15'h0000, 3'd2, 8'h00, 8'hFF, 8'hFF, 8'h00, 8'h00, 2'd3},
    {15'h3456, 3'd3, 8'h00, 8'h00, 8'h00, 8'h99, 8'h00, 2'd1},
    {15'h3456, 3'd4, 8'h00, 8'h00, 8'h00, 8'h10, 8'hAB, 2'd1},
    {15'h7FFF, 3'd0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 2'd1},
    {15'h7FFE, 3'd0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 2'd3},
    {15'h1234, 3'd7, 8'h05, 8'h00, 8'h00, 8'h00, 8'h00, 2'd2},
    {15'h1234, 3'd1, 8'h8C, 8'h00, 8'h00, 8'h00, 8'h00, 2'd1},
    {15'h7FF0, 3'd1, 8'h1F, 8'h00, 8'h00, 8'h00, 8'h00, 2'd1}
  };

  function automatic string vtag(input int i);
    case (i)
      0, 11:  return "R2";
      1:      return "R3";
      2:      return "R4";
      3:      return "R5";
      4, 10, 14: return "R14";
      5:      return "R6";
      6:      return "R7";
      7:      return "R9";
      8:      return "R10";
      9:      return "R11";
      default: return "R13";
    endcase
  endfunction

  // independent integer model of the requirements
  function automatic int model_next(input int pc, input int kind, input int opc,
                                    input int o1, input int o2, input int acc,
                                    input int tb, input int len);
    int seqv;
    seqv = (pc + len) % 32768;
    case (kind)
      1: begin
        if ((opc / 32) == 0 && (opc % 32) != 0) return (pc + 1 + (opc % 32)) % 32768;
        if ((opc / 32) == 7) return (pc + 1 + (opc % 32) + 32768 - 32) % 32768;
        if ((opc / 16) == 2 || (opc / 16) == 3)
          return (pc / 4096) * 4096 + (opc % 16) * 256 + o1;
        return seqv;
      end
      2: return (o1 % 128) * 256 + o2;
      3: return (pc / 256) * 256 + acc;
      4: return (pc / 256) * 256 + tb;
      default: return seqv;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    step_i = 1'b0; kind_i = 3'd0; opc_i = 8'h00; op1_i = 8'h00; op2_i = 8'h00;
    acc_i = 8'h00; tbyte_i = 8'h00; len_i = 2'd1;
  endtask

  // bring the PC to a chosen value through an absolute jump
  task automatic goto_pc(input logic [14:0] p);
    @(negedge clk_i);
    kind_i = 3'd2; op1_i = {1'b0, p[14:8]}; op2_i = p[7:0]; step_i = 1'b1;
    @(negedge clk_i);
    idle_inputs();
    check("R9", "goto pc_o", int'(pc_o), int'(p));
  endtask

  initial begin
    idle_inputs();
    rst_ni = 1'b0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    check("R1", "pc_o in reset", int'(pc_o), 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", "pc_o after release", int'(pc_o), 0);

    for (int i = 0; i < NV; i++) begin
      logic [59:0] v;
      int sp, k, oc, a1, a2, ac, tb, ln, expn, expush;
      v  = VECS[i];
      sp = int'(v[59:45]); k = int'(v[44:42]); oc = int'(v[41:34]);
      a1 = int'(v[33:26]); a2 = int'(v[25:18]); ac = int'(v[17:10]);
      tb = int'(v[9:2]);   ln = int'(v[1:0]);
      goto_pc(v[59:45]);
      expn   = model_next(sp, k, oc, a1, a2, ac, tb, ln);
      expush = (k == 1 && (oc / 16) == 3) ? 1 : 0;
      kind_i = v[44:42]; opc_i = v[41:34]; op1_i = v[33:26]; op2_i = v[25:18];
      acc_i = v[17:10]; tbyte_i = v[9:2]; len_i = v[1:0]; step_i = 1'b1;
      #2;
      check(vtag(i), "nxt_pc_o", int'(nxt_pc_o), expn);
      check(expush ? "R7" : "R8", "push_o", int'(push_o), expush);
      if (expush != 0) check("R7", "ret_o", int'(ret_o), (sp + ln) % 32768);
      if (k == 4) check("R11", "tbl_addr_o", int'(tbl_addr_o), (sp / 256) * 256 + ac);
      @(negedge clk_i);
      idle_inputs();
      check(vtag(i), "pc_o after step", int'(pc_o), expn);
    end

    // R12: no step keeps the PC even with a jump presented
    goto_pc(15'h0100);
    kind_i = 3'd2; op1_i = 8'h22; op2_i = 8'h33;
    repeat (2) @(negedge clk_i);
    check("R12", "pc_o held", int'(pc_o), 16'h0100);
    idle_inputs();

    // R1: reset in mid-run clears the PC at once
    goto_pc(15'h4321);
    rst_ni = 1'b0;
    #2;
    check("R1", "pc_o async reset", int'(pc_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check("R1", "pc_o after second release", int'(pc_o), 0);

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R0 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule